// File: doc/BRIEF.md
# Mantissa Rounding Stage

This block takes an unpacked floating-point mantissa whose two lowest bits hold the guard bit and the round bit. A separate sticky bit comes in beside it, together with the sign of the value and a 2-bit rounding-direction code. On each valid input it decides whether to add one unit in the last place of the retained mantissa. It then drops the guard and round positions. The result, a rounded-up flag and an inexact flag appear on registered outputs one clock later.

The retained result is one bit wider than the kept mantissa field, so a carry that ripples out of the top is preserved and is not wrapped. Detecting a mantissa that has reached 2.0, renormalising and adjusting the exponent are left to the surrounding datapath. That datapath uses the rounded-up flag to learn that a carry into the next binade may have happened.

Top module: `mant_rounder`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `round_up`, `inexact` and `mant_out` are all zero.
- R2: `mant_out` is always the input mantissa shifted right by two bits, zero-extended by one bit, plus one when `round_up` is set. The guard bit (`mant_in[1]`) and the round bit (`mant_in[0]`) never appear in the result.
- R3: When guard, round and sticky are all zero, the result is exact: `round_up` and `inexact` are both 0, whatever the mode and sign.
- R4: `inexact` is 1 exactly when at least one of guard, round or sticky is 1, in every mode.
- R5: Mode code 0 is round-to-nearest with ties to even. The increment happens only when guard is 1 and at least one of round, sticky or the LSB of the shifted mantissa is 1.
- R6: Mode code 1 is round-toward-zero. `round_up` is never set.
- R7: Mode code 2 is round-toward-plus-infinity. The increment happens exactly when the result is inexact and `sign_in` is 0.
- R8: Mode code 3 is round-toward-minus-infinity. The increment happens exactly when the result is inexact and `sign_in` is 1.
- R9: The increment carries across the whole retained width. An all-ones retained mantissa that rounds up yields `mant_out` with only its top bit (bit MANT_W) set.
- R10: The outputs describe the input of the previous clock. `out_valid` equals `in_valid` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand present |
| mant_in | input | MANT_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| mode_in | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result present |
| mant_out | output | MANT_W+1 | Rounded mantissa, carry bit at the top |
| round_up | output | 1 | An increment was applied |
| inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The assertions compare each registered result against the inputs of the previous cycle. They therefore assume that `mant_in`, `sticky_in`, `sign_in` and `mode_in` hold meaningful values whenever `in_valid` is high. They also assume that a checked result always follows a cycle in which the block was out of reset. The stimulus changes inputs only on falling edges and leaves at least one cycle between reset release and the first valid operand. It mixes random operands with forced ties (guard set, round and sticky clear) at both LSB parities, as well as all-ones mantissas that carry out of the top.

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W+1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic              out_valid,
  output logic [MANT_W:0]   mant_out,
  output logic              round_up,
  output logic              inexact
);
  localparam logic [1:0] MODE_NEAR = 2'd0;
  localparam logic [1:0] MODE_ZERO = 2'd1;
  localparam logic [1:0] MODE_POS  = 2'd2;
  localparam logic [1:0] MODE_NEG  = 2'd3;

  logic [MANT_W-1:0] kept;
  logic              g_bit, r_bit, lost, bump;
  logic [MANT_W:0]   sum;

  assign kept  = mant_in[MANT_W+1:2];
  assign g_bit = mant_in[1];
  assign r_bit = mant_in[0];
  assign lost  = g_bit | r_bit | sticky_in;

  always_comb begin
    case (mode_in)
      MODE_ZERO: bump = 1'b0;
      MODE_POS:  bump = lost & ~sign_in;
      MODE_NEG:  bump = lost & sign_in;
      MODE_NEAR: bump = g_bit & (r_bit | sticky_in | kept[0]);
      default:   bump = g_bit & (r_bit | sticky_in | kept[0]);
    endcase
  end

  assign sum = {1'b0, kept} + {{MANT_W{1'b0}}, bump};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mant_out  <= '0;
      round_up  <= 1'b0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mant_out <= sum;
        round_up <= bump;
        inexact  <= lost;
      end
    end
  end
endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
  parameter int MANT_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MANT_W+1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic              out_valid,
  input logic [MANT_W:0]   mant_out,
  input logic              round_up,
  input logic              inexact
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R3
  exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mant_in[1:0]) == 2'b00 && !$past(sticky_in) |-> !round_up && !inexact);

  // R4
  inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($past(mant_in[1:0]) != 2'b00 || $past(sticky_in)) |-> inexact);

  // R6
  toward_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode_in) == 2'd1 |-> !round_up);

  // R7
  pos_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode_in) == 2'd2 && $past(sign_in) |-> !round_up);

  // R8
  neg_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode_in) == 2'd3 && !$past(sign_in) |-> !round_up);

  // R2
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !round_up |-> mant_out == {1'b0, $past(mant_in[MANT_W+1:2])});

  // R9
  carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && round_up |-> mant_out == {1'b0, $past(mant_in[MANT_W+1:2])} + 1'b1);
endmodule

bind mant_rounder mant_rounder_chk #(.MANT_W(MANT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mant_in(mant_in),
  .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
  .out_valid(out_valid), .mant_out(mant_out), .round_up(round_up),
  .inexact(inexact)
);

// File: tb/mant_rounder_test.sv
module mant_rounder_test;
  localparam int MANT_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [MANT_W+1:0] mant_in = '0;
  logic              sticky_in = 1'b0;
  logic              sign_in = 1'b0;
  logic [1:0]        mode_in = 2'd0;
  logic              out_valid;
  logic [MANT_W:0]   mant_out;
  logic              round_up;
  logic              inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mant_rounder #(.MANT_W(MANT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mant_in(mant_in),
    .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
    .out_valid(out_valid), .mant_out(mant_out), .round_up(round_up),
    .inexact(inexact)
  );

  logic [MANT_W:0] exp_mant;
  logic            exp_up, exp_nx;

  task automatic model(input logic [MANT_W+1:0] m, input logic s, input logic sg,
                       input logic [1:0] md);
    longint unsigned base;
    int grs;
    base   = longint'(m) >> 2;
    grs    = int'(m[1:0]);
    exp_nx = (grs != 0) || s;
    if (md == 2'd1)      exp_up = 1'b0;
    else if (md == 2'd2) exp_up = exp_nx && !sg;
    else if (md == 2'd3) exp_up = exp_nx && sg;
    else                 exp_up = (grs >= 2) && ((grs == 3) || s || (base % 2 == 1));
    exp_mant = (MANT_W+1)'(base + (exp_up ? 1 : 0));
  endtask

  task automatic step(input logic [MANT_W+1:0] m, input logic s, input logic sg,
                      input logic [1:0] md, input string req);
    @(negedge clk);
    in_valid = 1'b1; mant_in = m; sticky_in = s; sign_in = sg; mode_in = md;
    model(m, s, sg, md);
    @(posedge clk); #2;
    checks++;
    if (!out_valid || mant_out !== exp_mant || round_up !== exp_up || inexact !== exp_nx) begin
      fails++;
      $display("FAIL %s: got v=%0b m=%h up=%0b nx=%0b, expected v=1 m=%h up=%0b nx=%0b",
               req, out_valid, mant_out, round_up, inexact, exp_mant, exp_up, exp_nx);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #20;
    checks++;
    // R1
    if (out_valid !== 1'b0 || mant_out !== '0 || round_up !== 1'b0 || inexact !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%0b m=%h up=%0b nx=%0b, expected all zero",
               out_valid, mant_out, round_up, inexact);
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R3 exact in every mode
    for (int md = 0; md < 4; md++) step(26'h3ABCDE0, 1'b0, md[0], 2'(md), "R3");
    // R2 guard/round dropped, nearest rounds down
    step(26'h1234565, 1'b0, 1'b0, 2'd0, "R2");
    // R4 sticky alone is inexact
    step(26'h0000100, 1'b1, 1'b0, 2'd1, "R4");
    // R5 ties: even stays, odd bumps; above half bumps
    step(26'h0000012, 1'b0, 1'b0, 2'd0, "R5");
    step(26'h0000016, 1'b0, 1'b0, 2'd0, "R5");
    step(26'h0000012, 1'b1, 1'b1, 2'd0, "R5");
    step(26'h0000013, 1'b0, 1'b0, 2'd0, "R5");
    // R6
    step(26'h0000017, 1'b1, 1'b0, 2'd1, "R6");
    // R7
    step(26'h0000011, 1'b0, 1'b0, 2'd2, "R7");
    step(26'h0000011, 1'b0, 1'b1, 2'd2, "R7");
    // R8
    step(26'h0000011, 1'b0, 1'b1, 2'd3, "R8");
    step(26'h0000011, 1'b0, 1'b0, 2'd3, "R8");
    // R9 carry out of the top
    step({MANT_W+2{1'b1}}, 1'b0, 1'b0, 2'd0, "R9");
    step({{MANT_W{1'b1}}, 2'b00}, 1'b1, 1'b1, 2'd3, "R9");

    // R10 idle cycle drops out_valid
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #2;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: got out_valid=%0b, expected 0", out_valid);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [MANT_W+1:0] m;
      logic s;
      logic [1:0] md;
      m  = (MANT_W+2)'({$urandom, $urandom});
      s  = 1'($urandom);
      md = 2'($urandom);
      if (i % 4 == 0) begin m[1:0] = 2'b10; s = 1'b0; end
      case (md)
        2'd0: step(m, s, 1'($urandom), md, "R5");
        2'd1: step(m, s, 1'($urandom), md, "R6");
        2'd2: step(m, s, 1'($urandom), md, "R7");
        default: step(m, s, 1'($urandom), md, "R8");
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule